// File: doc/BRIEF.md
# Satellite Physical-Layer Frame Symbol Sequencer

This block follows a single-carrier physical-layer frame one symbol at a time once an external correlator has found the frame start. A start pulse marks the first symbol of the frame. From then on every qualified symbol is labelled as header, data or pilot. The label comes with the running slot number, the running index among data symbols, and a pulse on the final data symbol. Downstream stages use these labels to strip pilots and to descramble only the payload. The block carries control tags only. Sample values never enter it and travel alongside it unchanged.

Each frame opens with a 90-symbol header. The payload that follows is cut into 90-symbol slots. The slot count follows from the coded frame length (64,800 or 16,200 bits) and the constellation order. When pilots are enabled, a 36-symbol pilot block follows every sixteenth slot, except after the last one. The constellation and frame-type inputs come from the header decoder. They are captured once per frame, on the last header symbol, so later changes on those inputs cannot disturb a frame already running. A start pulse that arrives while a frame is still running restarts the header and sets a sticky flag.

Top module: `plframe_seq`

## Requirements
- R1: After reset, `vld_o`, `eof_o` and `resync_o` are 0 and `tag_o` is 0.
- R2: Each symbol with `sym_vld_i` high gives exactly one labelled output with `vld_o` high in the following cycle. A cycle with `sym_vld_i` low gives `vld_o` 0 and `eof_o` 0 in the following cycle. Symbols outside any frame carry tag 0 (idle).
- R3: A symbol that carries `sof_i` together with `sym_vld_i` is header symbol 0. It and the next 89 valid symbols carry tag 1 (header), with `slot_o` and `didx_o` both 0.
- R4: Data symbols carry tag 2. A frame holds S·90 of them, where S = N/(90·b). N is 16,200 when `type_i[1]` is 1 and 64,800 when it is 0. b is `mod_i`+2, with codes 0..3 meaning QPSK, 8-PSK, 16-APSK and 32-APSK.
- R5: When `type_i[0]` was 1 at capture, 36 symbols with tag 3 (pilot) follow every 16th slot, but never the final slot, giving floor((S−1)/16) blocks. When it was 0, no pilot symbols appear.
- R6: On a data symbol, `didx_o` counts the data symbols of the frame from 0 and `slot_o` equals `didx_o`/90. On a pilot symbol, both outputs give the number of slots and data symbols already delivered. On idle and header symbols, both are 0.
- R7: `eof_o` is high only with the last data symbol of a frame. Valid symbols after it carry tag 0 until the next start pulse.
- R8: `mod_i` and `type_i` are sampled only on header symbol 89. Their values on every other symbol have no effect on the frame.
- R9: A start pulse while a frame is running (header, data or pilot, including its last data symbol) restarts the header and sets `resync_o`. `resync_o` stays high until reset. This includes a start pulse that replaces the last data symbol, in which case `eof_o` stays 0. A start pulse while idle, including the symbol right after `eof_o`, leaves `resync_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_vld_i | input | 1 | A symbol is present this cycle |
| sof_i | input | 1 | Current symbol is the first of a frame |
| mod_i | input | 2 | Constellation code: 0 QPSK, 1 8-PSK, 2 16-APSK, 3 32-APSK |
| type_i | input | 2 | Bit 1: short frame; bit 0: pilots present |
| vld_o | output | 1 | Labelled output valid |
| tag_o | output | 2 | 0 idle, 1 header, 2 data, 3 pilot |
| slot_o | output | 9 | Slot number (see R6) |
| didx_o | output | 15 | Data-symbol index (see R6) |
| eof_o | output | 1 | Last data symbol of the frame |
| resync_o | output | 1 | Sticky: frame restarted mid-frame |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the end of the final slot and the 16-slot pilot boundary. This happens whenever S is a multiple of 16. The bench runs the long 8-PSK frame (S = 240) to provoke it and expects `eof_o` with no pilot block after it. The second pair is a start pulse and the last data symbol. The bench replaces that symbol with a start pulse and expects a header tag, no `eof_o`, a set `resync_o`, and a clean next frame that continues from header symbol 1.

// File: rtl/plframe_pkg.sv
`timescale 1ns/1ps
package plframe_pkg;

  typedef enum logic [1:0] {
    TAG_IDLE  = 2'd0,
    TAG_HDR   = 2'd1,
    TAG_DATA  = 2'd2,
    TAG_PILOT = 2'd3
  } sym_tag_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_HDR,
    SQ_DATA,
    SQ_PILOT
  } seq_state_e;

  typedef struct packed {
    logic [1:0] mod;
    logic       short_frm;
    logic       pilots;
  } frame_cfg_t;

  // slots per frame for a given coded length and bits per symbol
  function automatic int slots_in_frame(input int bits, input int slot_len, input int bps);
    return bits / (slot_len * bps);
  endfunction

endpackage

// File: rtl/plframe_slot_calc.sv
`timescale 1ns/1ps
module plframe_slot_calc
  import plframe_pkg::*;
#(
  parameter int SLOT_LEN   = 90,
  parameter int LONG_BITS  = 64800,
  parameter int SHORT_BITS = 16200,
  parameter int SLOT_W     = 9
) (
  input  logic [1:0]        mod_i,
  input  logic              short_i,
  output logic [SLOT_W-1:0] last_slot_o
);

  logic [SLOT_W-1:0] long_last  [4];
  logic [SLOT_W-1:0] short_last [4];

  // one constant per constellation: bits per symbol is code + 2
  generate
    for (genvar g = 0; g < 4; g++) begin : g_mod
      localparam int LONG_N  = slots_in_frame(LONG_BITS,  SLOT_LEN, g + 2);
      localparam int SHORT_N = slots_in_frame(SHORT_BITS, SLOT_LEN, g + 2);
      assign long_last[g]  = SLOT_W'(LONG_N - 1);
      assign short_last[g] = SLOT_W'(SHORT_N - 1);
    end
  endgenerate

  assign last_slot_o = short_i ? short_last[mod_i] : long_last[mod_i];

endmodule

// File: rtl/plframe_seq_fsm.sv
`timescale 1ns/1ps
module plframe_seq_fsm
  import plframe_pkg::*;
#(
  parameter int HDR_LEN    = 90,
  parameter int SLOT_LEN   = 90,
  parameter int PLT_LEN    = 36,
  parameter int PLT_PERIOD = 16,
  parameter int POS_W      = 7,
  parameter int GRP_W      = 5,
  parameter int SLOT_W     = 9,
  parameter int DIDX_W     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_vld_i,
  input  logic              sof_i,
  input  frame_cfg_t        cfg_i,
  input  logic [SLOT_W-1:0] last_slot_i,
  output frame_cfg_t        cfg_q_o,
  output sym_tag_e          cur_tag_o,
  output logic [SLOT_W-1:0] cur_slot_o,
  output logic [DIDX_W-1:0] cur_didx_o,
  output logic              cur_eof_o,
  output logic              resync_o
);

  localparam logic [POS_W-1:0] HDR_END  = POS_W'(HDR_LEN - 1);
  localparam logic [POS_W-1:0] SLOT_END = POS_W'(SLOT_LEN - 1);
  localparam logic [POS_W-1:0] PLT_END  = POS_W'(PLT_LEN - 1);
  localparam logic [GRP_W-1:0] GRP_END  = GRP_W'(PLT_PERIOD - 1);

  seq_state_e        st_q,   st_d;
  logic [POS_W-1:0]  pos_q,  pos_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [GRP_W-1:0]  grp_q,  grp_d;
  logic [DIDX_W-1:0] didx_q, didx_d;
  frame_cfg_t        cfg_q,  cfg_d;
  logic              rs_q,   rs_d;

  // next state and label of the symbol presented this cycle
  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    slot_d = slot_q;
    grp_d  = grp_q;
    didx_d = didx_q;
    cfg_d  = cfg_q;
    rs_d   = rs_q;
    cur_slot_o = slot_q;
    cur_didx_o = didx_q;
    cur_eof_o  = 1'b0;
    case (st_q)
      SQ_HDR:   cur_tag_o = TAG_HDR;
      SQ_DATA:  cur_tag_o = TAG_DATA;
      SQ_PILOT: cur_tag_o = TAG_PILOT;
      default:  cur_tag_o = TAG_IDLE;
    endcase
    if (sym_vld_i) begin
      if (sof_i) begin
        // start pulse wins over anything in progress
        cur_tag_o  = TAG_HDR;
        cur_slot_o = '0;
        cur_didx_o = '0;
        st_d   = SQ_HDR;
        pos_d  = POS_W'(1);
        slot_d = '0;
        grp_d  = '0;
        didx_d = '0;
        if (st_q != SQ_IDLE) rs_d = 1'b1;
      end else begin
        case (st_q)
          SQ_HDR: begin
            if (pos_q == HDR_END) begin
              st_d  = SQ_DATA;
              pos_d = '0;
              cfg_d = cfg_i;
            end else begin
              pos_d = pos_q + 1'b1;
            end
          end
          SQ_DATA: begin
            didx_d = didx_q + 1'b1;
            if (pos_q == SLOT_END) begin
              pos_d = '0;
              if (slot_q == last_slot_i) begin
                cur_eof_o = 1'b1;
                st_d   = SQ_IDLE;
                slot_d = '0;
                didx_d = '0;
                grp_d  = '0;
              end else begin
                slot_d = slot_q + 1'b1;
                if (cfg_q.pilots && grp_q == GRP_END) begin
                  st_d  = SQ_PILOT;
                  grp_d = '0;
                end else begin
                  grp_d = grp_q + 1'b1;
                end
              end
            end else begin
              pos_d = pos_q + 1'b1;
            end
          end
          SQ_PILOT: begin
            if (pos_q == PLT_END) begin
              st_d  = SQ_DATA;
              pos_d = '0;
            end else begin
              pos_d = pos_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      pos_q  <= '0;
      slot_q <= '0;
      grp_q  <= '0;
      didx_q <= '0;
      cfg_q  <= '0;
      rs_q   <= 1'b0;
    end else if (sym_vld_i) begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      slot_q <= slot_d;
      grp_q  <= grp_d;
      didx_q <= didx_d;
      cfg_q  <= cfg_d;
      rs_q   <= rs_d;
    end
  end

  assign cfg_q_o  = cfg_q;
  assign resync_o = rs_q;

endmodule

// File: rtl/plframe_tag_reg.sv
`timescale 1ns/1ps
module plframe_tag_reg #(
  parameter int SLOT_W = 9,
  parameter int DIDX_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [1:0]        tag_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DIDX_W-1:0] didx_i,
  input  logic              eof_i,
  output logic              vld_o,
  output logic [1:0]        tag_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [DIDX_W-1:0] didx_o,
  output logic              eof_o
);

  logic eof_d;

  assign eof_d = vld_i & eof_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      eof_o  <= 1'b0;
      tag_o  <= '0;
      slot_o <= '0;
      didx_o <= '0;
    end else begin
      vld_o <= vld_i;
      eof_o <= eof_d;
      if (vld_i) begin
        tag_o  <= tag_i;
        slot_o <= slot_i;
        didx_o <= didx_i;
      end
    end
  end

endmodule

// File: rtl/plframe_seq.sv
`timescale 1ns/1ps
module plframe_seq
  import plframe_pkg::*;
#(
  parameter  int HDR_LEN    = 90,
  parameter  int SLOT_LEN   = 90,
  parameter  int PLT_LEN    = 36,
  parameter  int PLT_PERIOD = 16,
  parameter  int LONG_BITS  = 64800,
  parameter  int SHORT_BITS = 16200,
  localparam int MAX_SLOTS  = LONG_BITS / (SLOT_LEN * 2),
  localparam int SLOT_W     = $clog2(MAX_SLOTS),
  localparam int DIDX_W     = $clog2(MAX_SLOTS * SLOT_LEN),
  localparam int MAX_LEN    = (HDR_LEN > SLOT_LEN) ? HDR_LEN : SLOT_LEN,
  localparam int POS_W      = $clog2(MAX_LEN),
  localparam int GRP_W      = $clog2(PLT_PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_vld_i,
  input  logic              sof_i,
  input  logic [1:0]        mod_i,
  input  logic [1:0]        type_i,
  output logic              vld_o,
  output logic [1:0]        tag_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [DIDX_W-1:0] didx_o,
  output logic              eof_o,
  output logic              resync_o
);

  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  frame_cfg_t        cfg_in, cfg_q;
  logic [SLOT_W-1:0] last_slot;
  sym_tag_e          cur_tag;
  logic [SLOT_W-1:0] cur_slot;
  logic [DIDX_W-1:0] cur_didx;
  logic              cur_eof;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign cfg_in = '{mod: mod_i, short_frm: type_i[1], pilots: type_i[0]};

  plframe_slot_calc #(
    .SLOT_LEN(SLOT_LEN), .LONG_BITS(LONG_BITS), .SHORT_BITS(SHORT_BITS), .SLOT_W(SLOT_W)
  ) u_slots (
    .mod_i(cfg_q.mod), .short_i(cfg_q.short_frm), .last_slot_o(last_slot)
  );

  plframe_seq_fsm #(
    .HDR_LEN(HDR_LEN), .SLOT_LEN(SLOT_LEN), .PLT_LEN(PLT_LEN), .PLT_PERIOD(PLT_PERIOD),
    .POS_W(POS_W), .GRP_W(GRP_W), .SLOT_W(SLOT_W), .DIDX_W(DIDX_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .sym_vld_i(sym_vld_i), .sof_i(sof_i),
    .cfg_i(cfg_in), .last_slot_i(last_slot), .cfg_q_o(cfg_q),
    .cur_tag_o(cur_tag), .cur_slot_o(cur_slot), .cur_didx_o(cur_didx),
    .cur_eof_o(cur_eof), .resync_o(resync_o)
  );

  plframe_tag_reg #(.SLOT_W(SLOT_W), .DIDX_W(DIDX_W)) u_out (
    .clk(clk), .rst_n(rst_n_s), .vld_i(sym_vld_i), .tag_i(cur_tag),
    .slot_i(cur_slot), .didx_i(cur_didx), .eof_i(cur_eof),
    .vld_o(vld_o), .tag_o(tag_o), .slot_o(slot_o), .didx_o(didx_o), .eof_o(eof_o)
  );

endmodule

// File: rtl/plframe_seq_chk.sv
`timescale 1ns/1ps
module plframe_seq_chk #(
  parameter int SLOT_LEN = 90,
  parameter int SLOT_W   = 9,
  parameter int DIDX_W   = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sym_vld_i,
  input logic              sof_i,
  input logic              vld_o,
  input logic [1:0]        tag_o,
  input logic [SLOT_W-1:0] slot_o,
  input logic [DIDX_W-1:0] didx_o,
  input logic              eof_o,
  input logic              resync_o
);

  a_r2_no_input_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld_i |=> (!vld_o && !eof_o));

  a_r3_sof_opens_header: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld_i && sof_i) |=> (vld_o && tag_o == 2'd1 && slot_o == '0 && didx_o == '0));

  a_r6_slot_follows_index: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && tag_o == 2'd2) |->
      (int'(slot_o) * SLOT_LEN <= int'(didx_o) && int'(didx_o) < (int'(slot_o) + 1) * SLOT_LEN));

  a_r7_eof_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> (vld_o && tag_o == 2'd2));

  a_r9_resync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    resync_o |=> resync_o);

endmodule

bind plframe_seq plframe_seq_chk #(.SLOT_LEN(SLOT_LEN), .SLOT_W(SLOT_W), .DIDX_W(DIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .sym_vld_i(sym_vld_i), .sof_i(sof_i), .vld_o(vld_o),
  .tag_o(tag_o), .slot_o(slot_o), .didx_o(didx_o), .eof_o(eof_o), .resync_o(resync_o)
);

// File: tb/plframe_seq_test.sv
`timescale 1ns/1ps
module plframe_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sym_vld = 1'b0;
  logic        sof = 1'b0;
  logic [1:0]  mod = 2'd0;
  logic [1:0]  typ = 2'd0;
  logic        vld_o, eof_o, resync_o;
  logic [1:0]  tag_o;
  logic [8:0]  slot_o;
  logic [14:0] didx_o;

  int n_chk = 0, n_fail = 0;
  int f_err, f_hdr, f_dat, f_plt, f_eof;

  always #(CLK_PERIOD / 2) clk = ~clk;

  plframe_seq uut (
    .clk(clk), .rst_n(rst_n), .sym_vld_i(sym_vld), .sof_i(sof), .mod_i(mod), .type_i(typ),
    .vld_o(vld_o), .tag_o(tag_o), .slot_o(slot_o), .didx_o(didx_o), .eof_o(eof_o),
    .resync_o(resync_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_tally();
    f_err = 0; f_hdr = 0; f_dat = 0; f_plt = 0; f_eof = 0;
  endtask

  // one valid symbol; compare the label that appears after the next edge
  task automatic sym_step(input bit s, input logic [1:0] m, input logic [1:0] t,
                          input int etag, input int eslot, input int edidx, input bit eeof);
    @(negedge clk);
    sym_vld = 1'b1; sof = s; mod = m; typ = t;
    @(posedge clk); #1;
    if (vld_o) begin
      if (tag_o == 2'd1) f_hdr++;
      if (tag_o == 2'd2) f_dat++;
      if (tag_o == 2'd3) f_plt++;
    end
    if (eof_o) f_eof++;
    if (!vld_o || tag_o != etag || slot_o != eslot || didx_o != edidx || eof_o != eeof) begin
      if (f_err == 0)
        $display("  first mismatch: tag %0d/%0d slot %0d/%0d idx %0d/%0d eof %0d/%0d",
                 tag_o, etag, slot_o, eslot, didx_o, edidx, eof_o, eeof);
      f_err++;
    end
  endtask

  task automatic gap_step();
    @(negedge clk);
    sym_vld = 1'b0; sof = 1'b0;
    @(posedge clk); #1;
    if (vld_o || eof_o) f_err++;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; sym_vld = 1'b0; sof = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(vld_o == 1'b0, "R1", "vld_o after reset", vld_o, 0);
    check(eof_o == 1'b0 && tag_o == 2'd0, "R1", "eof_o/tag_o after reset", {eof_o, tag_o}, 0);
    check(resync_o == 1'b0, "R1", "resync_o after reset", resync_o, 0);
  endtask

  // drive one frame; mod/type hold the right values only on header symbol 89
  task automatic run_frame(input int m, input bit shrt, input bit pil, input int gap_every,
                           input bit first_sent, input bit cut_last, input string name);
    int S, di, nsym, exp_plt;
    logic [1:0] mm, t;
    bit last;
    mm = m[1:0];
    t = {shrt, pil};
    S = (shrt ? 180 : 720) / (m + 2);
    di = 0;
    nsym = 0;
    clear_tally();
    for (int h = (first_sent ? 1 : 0); h < 90; h++) begin
      sym_step(h == 0, (h == 89) ? mm : ~mm, (h == 89) ? t : ~t, 1, 0, 0, 1'b0);
      nsym++;
      if (gap_every > 0 && nsym % gap_every == 0) gap_step();
    end
    for (int s = 0; s < S; s++) begin
      for (int p = 0; p < 90; p++) begin
        last = (s == S - 1) && (p == 89);
        if (last && cut_last) sym_step(1'b1, ~mm, ~t, 1, 0, 0, 1'b0);
        else                  sym_step(1'b0, ~mm, ~t, 2, s, di, last);
        di++;
        nsym++;
        if (gap_every > 0 && nsym % gap_every == 0) gap_step();
      end
      if (pil && ((s + 1) % 16 == 0) && s != S - 1)
        for (int q = 0; q < 36; q++) sym_step(1'b0, ~mm, ~t, 3, s + 1, di, 1'b0);
    end
    exp_plt = pil ? ((S - 1) / 16) * 36 : 0;
    $display("  frame %s: S=%0d", name, S);
    check(f_hdr == 90 - int'(first_sent) + int'(cut_last), "R3", {name, " header symbols"}, f_hdr,
          90 - int'(first_sent) + int'(cut_last));
    check(f_dat == S * 90 - int'(cut_last), "R4", {name, " data symbols"}, f_dat, S * 90 - int'(cut_last));
    check(f_plt == exp_plt, "R5", {name, " pilot symbols"}, f_plt, exp_plt);
    check(f_eof == (cut_last ? 0 : 1), "R7", {name, " end pulses"}, f_eof, cut_last ? 0 : 1);
    check(f_err == 0, "R6,R8", {name, " per-symbol label mismatches"}, f_err, 0);
  endtask

  task automatic t_idle();
    clear_tally();
    for (int i = 0; i < 5; i++) sym_step(1'b0, 2'd0, 2'd0, 0, 0, 0, 1'b0);
    gap_step();
    check(f_err == 0, "R2", "idle symbols tagged 0, gap gives no output", f_err, 0);
  endtask

  task automatic t_frames();
    run_frame(0, 1'b0, 1'b1, 0, 1'b0, 1'b0, "long QPSK pilots");
    run_frame(1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "long 8PSK pilots, last slot on boundary");
    run_frame(3, 1'b1, 1'b1, 5, 1'b0, 1'b0, "short 32APSK pilots with gaps");
    run_frame(0, 1'b1, 1'b0, 0, 1'b0, 1'b0, "short QPSK no pilots");
  endtask

  task automatic t_back_to_back();
    run_frame(2, 1'b1, 1'b1, 0, 1'b0, 1'b0, "short 16APSK first");
    run_frame(3, 1'b1, 1'b1, 0, 1'b0, 1'b0, "short 32APSK right after end");
    clear_tally();
    sym_step(1'b0, 2'd0, 2'd0, 0, 0, 0, 1'b0);
    check(f_err == 0, "R7", "symbol after end pulse tagged idle", f_err, 0);
    check(resync_o == 1'b0, "R9", "start while idle leaves resync_o", resync_o, 0);
  endtask

  task automatic t_sof_on_last();
    run_frame(3, 1'b1, 1'b1, 0, 1'b0, 1'b1, "start pulse on last data symbol");
    check(resync_o == 1'b1, "R9", "resync_o after start on last symbol", resync_o, 1);
    run_frame(3, 1'b1, 1'b1, 0, 1'b1, 1'b0, "frame after collision");
  endtask

  task automatic t_mid_resync();
    sym_step(1'b1, 2'd0, 2'd0, 1, 0, 0, 1'b0);
    for (int i = 0; i < 499; i++) sym_step(1'b0, 2'd1, 2'd3, (i < 89) ? 1 : 2, 0, 0, 1'b0);
    check(resync_o == 1'b0, "R9", "resync_o before mid-frame start", resync_o, 0);
    run_frame(0, 1'b1, 1'b0, 0, 1'b0, 1'b0, "after mid-frame restart");
    check(resync_o == 1'b1, "R9", "resync_o held after mid-frame start", resync_o, 1);
  endtask

  initial begin
    apply_reset();
    t_idle();
    t_frames();
    t_back_to_back();
    t_sof_on_last();
    apply_reset();
    t_mid_resync();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule